// File: doc/BRIEF.md
# Real-Time Counter Wakeup Timer

This block is an always-on timebase that turns a slow reference into millisecond ticks and raises wakeup events from them. A two-stage prescaler accepts pulses from one of two tick sources. The low-rate source is divided once. The high-rate source is divided first by a fixed pre-divider and then by the same final divider. The prescaler output advances a free-running counter.

Three events are derived from the counter. A long-interval match compares a slice of the counter with a programmable value and fires when the counter lands exactly on that slice value with every bit below the slice clear. A short-interval periodic compare fires whenever the low counter bits equal a programmable value. A rollover event fires when the counter wraps to zero. Each event sets its own sticky flag. The wakeup request is the OR of the flags whose enables are set. Software programs the block through a small write port and clears a flag by writing 1 to its bit.

Top module: `rtc_wake_timer`

## Requirements
- R1: After reset the counter output is 0, all three flags are 0, the wakeup request is 0, and every control field is 0.
- R2: Address 0 is the control word. Bit 0 enables the counter, bit 1 selects the tick source (0 = low-rate, 1 = high-rate), and bits 2, 3 and 4 enable the match, rollover and periodic wakeups. With the low-rate source selected and the counter enabled, the counter advances by 1 on every SLOW_DIV-th low-rate pulse.
- R3: With the high-rate source selected, the counter advances once per FAST_DIV*SLOW_DIV high-rate pulses. Pulses on the source that is not selected are ignored.
- R4: While the counter is disabled, tick pulses are ignored, the counter holds its value, no event fires, and both prescaler phases return to zero.
- R5: The match value sits at address 1. Flag bit 0 sets on the increment that makes counter bits [MATCH_LSB+MATCH_W-1:MATCH_LSB] equal the match value while bits below MATCH_LSB are zero.
- R6: The period value sits at address 2. Flag bit 2 sets on every increment that makes the low PER_W counter bits equal the period value.
- R7: Flag bit 1 sets on the increment that wraps the counter from all ones to zero.
- R8: Flags are sticky. A write to address 3 clears each flag whose data bit is 1, a 0 bit leaves its flag unchanged, and an event in the same cycle as a clear leaves the flag set.
- R9: The wakeup request is high exactly when some flag is set whose enable bit (control bit 2 for flag 0, bit 3 for flag 1, bit 4 for flag 2) is also set.
- R10: Rewriting the match or period value while the counter runs takes effect from the next increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse from the low-rate reference |
| fast_tick | input | 1 | One-cycle pulse from the high-rate reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 match, 2 period, 3 flag clear |
| wr_data | input | DATA_W | Register write data |
| cnt_o | output | CNT_W | Current counter value |
| flag_o | output | 3 | Sticky flags: bit 0 match, bit 1 rollover, bit 2 periodic |
| wake_req | output | 1 | Combined wakeup request |

## Verification
A prescaler that has the wrong phase shows up on `cnt_o` at the next increment. That is at most SLOW_DIV selected pulses later, or FAST_DIV*SLOW_DIV when the high-rate source is selected. A wrong slice position or wrong compare width sets a flag on the wrong count or on no count at all, and this becomes visible on `flag_o` in the same cycle as the increment. A wrong enable mapping or wrong clear handling shows at once on `wake_req` and `flag_o` after the write that exercises it. The bench sweeps a reduced configuration through a complete counter wrap while a model predicts every increment and event, so any of these faults is caught within one period of the faulty value.

// File: rtl/rtc_wake_pkg.sv
// Shared definitions for the wakeup timer: register addresses, flag
// positions and the control word layout. Assumes a 2-bit address space.
package rtc_wake_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_MATCH  = 2'd1,
        ADDR_PERIOD = 2'd2,
        ADDR_FLAGS  = 2'd3
    } rtc_addr_e;

    localparam int EVT_N     = 3;
    localparam int FLG_MATCH = 0;
    localparam int FLG_ROLL  = 1;
    localparam int FLG_PER   = 2;

    // Control word; the field order gives the bit positions 4..0.
    typedef struct packed {
        logic per_en;
        logic roll_en;
        logic match_en;
        logic clk_sel;
        logic cnt_en;
    } rtc_ctrl_t;

endpackage

// File: rtl/rtc_regs.sv
// Register file: holds the control word, the match value and the period
// value, and turns a write to the flag address into a one-cycle clear mask.
// Assumes DATA_W is at least as wide as every field.
module rtc_regs
    import rtc_wake_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MATCH_W = 12,
    parameter int PER_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rtc_ctrl_t         ctrl,
    output logic [MATCH_W-1:0] match_val,
    output logic [PER_W-1:0]  per_val,
    output logic [EVT_N-1:0]  clr_mask
);
    localparam int CTRL_W = $bits(rtc_ctrl_t);

    // Capture configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            match_val <= '0;
            per_val   <= '0;
        end else if (wr_en) begin
            case (rtc_addr_e'(wr_addr))
                ADDR_CTRL:   ctrl      <= rtc_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_MATCH:  match_val <= wr_data[MATCH_W-1:0];
                ADDR_PERIOD: per_val   <= wr_data[PER_W-1:0];
                default:     ;
            endcase
        end
    end

    // Clear mask is live only during a write to the flag address.
    always_comb begin
        clr_mask = '0;
        if (wr_en && rtc_addr_e'(wr_addr) == ADDR_FLAGS)
            clr_mask = wr_data[EVT_N-1:0];
    end
endmodule

// File: rtl/rtc_prescaler.sv
// Two-stage tick prescaler. The high-rate source passes a FAST_DIV
// pre-divider, then the selected source passes a SLOW_DIV divider that
// produces one increment pulse. Both phases reset while not running.
// Assumes tick inputs are single-cycle pulses synchronous to clk.
module rtc_prescaler #(
    parameter int SLOW_DIV = 32,
    parameter int FAST_DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_fast,
    input  logic slow_tick,
    input  logic fast_tick,
    output logic inc
);
    localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [FW-1:0] F_LAST = FW'(FAST_DIV - 1);
    localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);

    logic          fast_out;
    logic          src;
    logic [SW-1:0] s_ph;

    generate
        if (FAST_DIV > 1) begin : g_fdiv
            logic [FW-1:0] f_ph;
            // Pre-divider phase for the high-rate source.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    f_ph <= '0;
                else if (sel_fast && fast_tick)
                    f_ph <= (f_ph == F_LAST) ? '0 : f_ph + 1'b1;
            end
            assign fast_out = run && sel_fast && fast_tick && (f_ph == F_LAST);
        end else begin : g_fbyp
            assign fast_out = run && sel_fast && fast_tick;
        end
    endgenerate

    assign src = sel_fast ? fast_out : (run && slow_tick);

    // Final divider phase shared by both sources.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            s_ph <= '0;
        else if (src)
            s_ph <= (s_ph == S_LAST) ? '0 : s_ph + 1'b1;
    end

    assign inc = src && (s_ph == S_LAST);
endmodule

// File: rtl/rtc_count_core.sv
// Free-running counter with event detection. Events are single-cycle
// pulses aligned with the increment and judged on the value being loaded.
// Assumes MATCH_LSB + MATCH_W <= CNT_W and PER_W <= CNT_W.
module rtc_count_core
    import rtc_wake_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int MATCH_LSB = 10,
    parameter int MATCH_W   = 12,
    parameter int PER_W     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic [MATCH_W-1:0] match_val,
    input  logic [PER_W-1:0]   per_val,
    output logic [CNT_W-1:0]   cnt,
    output logic [EVT_N-1:0]   evt
);
    logic [CNT_W-1:0] nxt;
    logic             low_clear;

    assign nxt = cnt + 1'b1;

    generate
        if (MATCH_LSB > 0) begin : g_low
            assign low_clear = (nxt[MATCH_LSB-1:0] == '0);
        end else begin : g_nolow
            assign low_clear = 1'b1;
        end
    endgenerate

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc)
            cnt <= nxt;
    end

    // Event decode on the incoming value.
    always_comb begin
        evt            = '0;
        evt[FLG_ROLL]  = inc && (cnt == '1);
        evt[FLG_MATCH] = inc && low_clear && (nxt[MATCH_LSB +: MATCH_W] == match_val);
        evt[FLG_PER]   = inc && (nxt[PER_W-1:0] == per_val);
    end
endmodule

// File: rtl/rtc_flags.sv
// Sticky cause flags: an event sets its bit, a clear mask bit resets it,
// and a set in the same cycle wins over the clear.
module rtc_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // One sticky bit with set priority.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[i] <= 1'b0;
                else if (set[i])
                    flags[i] <= 1'b1;
                else if (clr[i])
                    flags[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_wake_timer.sv
// Top of the wakeup timer: register file, prescaler, counter with event
// decode and sticky flags; the wakeup request ORs the enabled flags.
// Assumes all inputs are synchronous to clk.
module rtc_wake_timer
    import rtc_wake_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    parameter int MATCH_LSB = 10,
    parameter int MATCH_W   = 12,
    parameter int PER_W     = 10,
    parameter int SLOW_DIV  = 32,
    parameter int FAST_DIV  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [2:0]        flag_o,
    output logic              wake_req
);
    rtc_ctrl_t          ctrl_q;
    logic [MATCH_W-1:0] match_q;
    logic [PER_W-1:0]   per_q;
    logic [EVT_N-1:0]   clr_mask;
    logic [EVT_N-1:0]   evt;
    logic [EVT_N-1:0]   en_vec;
    logic               inc;
    logic               cnt_run;

    assign cnt_run = ctrl_q.cnt_en;

    rtc_regs #(.DATA_W(DATA_W), .MATCH_W(MATCH_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl_q), .match_val(match_q),
        .per_val(per_q), .clr_mask(clr_mask)
    );

    rtc_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cnt_run), .sel_fast(ctrl_q.clk_sel),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .inc(inc)
    );

    rtc_count_core #(.CNT_W(CNT_W), .MATCH_LSB(MATCH_LSB), .MATCH_W(MATCH_W),
                     .PER_W(PER_W)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .match_val(match_q),
        .per_val(per_q), .cnt(cnt_o), .evt(evt)
    );

    rtc_flags #(.N(EVT_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(evt), .clr(clr_mask), .flags(flag_o)
    );

    // Enable vector in flag order, then the masked OR.
    always_comb begin
        en_vec            = '0;
        en_vec[FLG_MATCH] = ctrl_q.match_en;
        en_vec[FLG_ROLL]  = ctrl_q.roll_en;
        en_vec[FLG_PER]   = ctrl_q.per_en;
        wake_req          = |(flag_o & en_vec);
    end
endmodule

// File: rtl/rtc_wake_chk.sv
// Property checker for the wakeup timer, bound to every instance of the top.
module rtc_wake_chk #(
    parameter int CNT_W     = 32,
    parameter int MATCH_LSB = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [CNT_W-1:0] cnt_o,
    input logic [2:0]       flag_o,
    input logic [2:0]       clr,
    input logic             wake_req
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_o == '0 && flag_o == '0 && !wake_req));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_o));

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '1) |=> (cnt_o == '1 || flag_o[1]));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flag_o) & ~$past(clr) & ~flag_o) == 3'b000));

    // R9
    wake_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (flag_o != 3'b000));

    generate
        if (MATCH_LSB > 0) begin : g_m
            // R5
            match_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_o[0]) |-> (cnt_o[MATCH_LSB-1:0] == '0));
        end
    endgenerate
endmodule

bind rtc_wake_timer rtc_wake_chk #(.CNT_W(CNT_W), .MATCH_LSB(MATCH_LSB)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_run), .cnt_o(cnt_o),
    .flag_o(flag_o), .clr(clr_mask), .wake_req(wake_req)
);

// File: tb/sim_rtc_wake_timer.sv
module sim_rtc_wake_timer;
    localparam int DW = 16, CW = 10, ML = 3, MW = 4, PW = 3, SD = 3, FD = 4;
    localparam int CMASK = (1 << CW) - 1;
    localparam int MMASK = (1 << MW) - 1;
    localparam int PMASK = (1 << PW) - 1;

    logic clk = 0, rst_n = 0, slow_tick = 0, fast_tick = 0, wr_en = 0;
    logic [1:0] wr_addr = 0;
    logic [DW-1:0] wr_data = 0;
    logic [CW-1:0] cnt_o;
    logic [2:0] flag_o;
    logic wake_req;

    int checks = 0, errors = 0;
    bit done = 0;
    int mcnt = 0, fph = 0, sph = 0, mmatch = 0, mper = 0;
    bit men = 0, msel = 0;
    bit [2:0] mflags = 0, menab = 0;

    always #5 clk = ~clk;

    rtc_wake_timer #(.DATA_W(DW), .CNT_W(CW), .MATCH_LSB(ML), .MATCH_W(MW),
                     .PER_W(PW), .SLOW_DIV(SD), .FAST_DIV(FD)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .flag_o(flag_o), .wake_req(wake_req)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string cnt_tag);
        chk(cnt_tag, cnt_o, mcnt);
        chk("R5 match flag", flag_o[0], mflags[0]);
        chk("R7 rollover flag", flag_o[1], mflags[1]);
        chk("R6 periodic flag", flag_o[2], mflags[2]);
        chk("R9 wake_req", wake_req, |(mflags & menab));
    endtask

    // One cycle of stimulus, then model update in the order the edge applies it.
    task automatic step(bit ps, bit pf, bit wr, int a, int d);
        bit src, inc;
        bit [2:0] evt, clr;
        int old;
        @(negedge clk);
        slow_tick = ps; fast_tick = pf; wr_en = wr;
        wr_addr = 2'(a); wr_data = DW'(d);
        @(negedge clk);
        slow_tick = 0; fast_tick = 0; wr_en = 0;
        src = 0; inc = 0; evt = 0;
        if (!men) begin
            fph = 0; sph = 0;
        end else begin
            if (msel) begin
                if (pf) begin
                    if (fph == FD - 1) begin fph = 0; src = 1; end
                    else fph++;
                end
            end else src = ps;
            if (src) begin
                if (sph == SD - 1) begin sph = 0; inc = 1; end
                else sph++;
            end
        end
        if (inc) begin
            old = mcnt;
            mcnt = (mcnt + 1) & CMASK;
            if (old == CMASK) evt[1] = 1;
            if (((mcnt >> ML) & MMASK) == mmatch && (mcnt % (1 << ML)) == 0) evt[0] = 1;
            if ((mcnt & PMASK) == mper) evt[2] = 1;
        end
        clr = (wr && a == 3) ? 3'(d) : 3'b000;
        mflags = (mflags & ~clr) | evt;
        if (wr) begin
            case (a)
                0: begin men = d[0]; msel = d[1]; menab = 3'((d >> 2) & 7); end
                1: mmatch = d & MMASK;
                2: mper = d & PMASK;
                default: ;
            endcase
        end
    endtask

    task automatic wr(int a, int d);
        step(0, 0, 1, a, d);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt_o, 0);
        chk("R1 flags", flag_o, 0);
        chk("R1 wake", wake_req, 0);

        // R4: pulses while disabled are ignored
        for (int i = 0; i < 7; i++) begin step(1, 1, 0, 0, 0); check_all("R4 cnt held"); end

        // R2/R5/R6/R7: full wrap on the low-rate source, all enables on
        wr(1, 5); wr(2, 6); wr(0, 5'b11101);
        for (int i = 0; i < (CMASK + 1) * SD + 20; i++) begin
            step(1, (i % 5) == 0, (i % 97) == 96, 3, 3'b111);
            check_all("R2 slow count");
        end

        // R8: writing 0 leaves flags alone, writing 1 clears
        for (int i = 0; i < SD * 8; i++) step(1, 0, 0, 0, 0);
        wr(3, 0);
        check_all("R8 cnt");
        chk("R8 zero write keeps flags", flag_o, mflags);
        wr(3, 3'b111);
        chk("R8 clear all", flag_o, 0);

        // R10: rewrite match and period while running
        wr(1, (((mcnt >> ML) + 2) & MMASK));
        wr(2, (mcnt + 3) & PMASK);
        for (int i = 0; i < (2 << ML) * SD + 6; i++) begin
            step(1, 0, i == 9, 2, (mcnt + 1) & PMASK);
            check_all("R10 count after rewrite");
        end

        // R9: only rollover enabled, flags pending for match/periodic
        wr(0, 5'b01001);
        check_all("R9 masked enables");
        wr(0, 5'b10001);
        check_all("R9 periodic enable");

        // R4: disable resets prescaler phase; R8 set beats clear
        step(1, 0, 0, 0, 0);
        wr(0, 0);
        for (int i = 0; i < 4; i++) begin step(1, 0, 0, 0, 0); check_all("R4 disabled hold"); end
        wr(3, 3'b111);
        wr(2, (mcnt + 1) & PMASK);
        wr(0, 5'b10001);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        step(1, 0, 1, 3, 3'b100);
        chk("R8 set wins over clear", flag_o[2], 1);
        check_all("R8 cnt");

        // R3: high-rate source, low-rate pulses ignored
        wr(0, 0);
        wr(0, 5'b11111);
        for (int i = 0; i < FD * SD * 40; i++) begin
            step((i % 3) == 0, (i % 4) != 3, 0, 0, 0);
            check_all("R3 fast count");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule